// File: doc/BRIEF.md
# Write Address Arbiter with Data Ordering

This block sits in front of one destination port of a write crossbar. Several sources can present write address requests at once. A rotating-priority arbiter picks one of them, and it can issue one grant in every clock cycle. Each grant is handed to the destination together with the index of the winning source. The same index is appended to a small ordering queue.

Write data beats are then taken only from the source at the front of that queue. They are forwarded to the destination until the beat marked last is accepted, and then the queue advances. As a result, data reaches the destination in the same source order as the addresses did. A single-beat write takes one cycle on the data side, the same as one beat of a longer burst.

A crossbar uses one instance of this block per destination. Every destination therefore arbitrates on its own, and transfers to different destinations proceed in parallel.

Top module: `wrOrderArb`

## Requirements
- R1: After reset the ordering queue is empty, the rotation pointer is 0, `dstWValid` is 0, every `srcWReady` bit is 0, and `dstAwValid` is 0 while no source requests.
- R2: The source granted is the first source with `srcAwValid` set, searching upward from the rotation pointer with wrap-around. After each accepted grant of source g, the pointer becomes g+1, or 0 when g is the last source.
- R3: `srcAwReady` has at most one bit set. Bit g is set only when g is the granted source and `dstAwReady` is high. `dstAwSrc` carries g, and `dstAwAddr` carries source g's address, taken from bits g*ADDR_W upward of `srcAwAddr`.
- R4: Only the source at the front of the ordering queue can see `srcWReady` high, and only while `dstWReady` is high. Every other source sees 0.
- R5: The front entry leaves the queue in the cycle where the front source's beat has `srcWValid`, `srcWLast` and `dstWReady` all high.
- R6: While the queue holds FIFO_DEPTH entries, `dstAwValid` and every `srcAwReady` bit are 0.
- R7: When the queue is not full and at least one source requests, `dstAwValid` is 1 in that cycle, so back-to-back grants happen on consecutive cycles.
- R8: `dstWValid`, `dstWData` and `dstWLast` equal the front source's `srcWValid`, data slice and `srcWLast`. The data slice is the bits from front*DATA_W upward of `srcWData`.
- R9: While the queue is empty, `dstWValid` is 0, so no data beat passes ahead of its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcAwValid | input | NUM_SRC | Write address request per source |
| srcAwAddr | input | NUM_SRC*ADDR_W | Packed addresses, source i at bits i*ADDR_W upward |
| srcAwReady | output | NUM_SRC | Address accepted, per source |
| dstAwValid | output | 1 | Address valid toward destination |
| dstAwAddr | output | ADDR_W | Granted address |
| dstAwSrc | output | $clog2(NUM_SRC) | Index of granted source |
| dstAwReady | input | 1 | Destination accepts address |
| srcWValid | input | NUM_SRC | Data beat valid per source |
| srcWData | input | NUM_SRC*DATA_W | Packed data, source i at bits i*DATA_W upward |
| srcWLast | input | NUM_SRC | Last beat of burst per source |
| srcWReady | output | NUM_SRC | Data beat accepted, per source |
| dstWValid | output | 1 | Data beat valid toward destination |
| dstWData | output | DATA_W | Forwarded data |
| dstWLast | output | 1 | Forwarded last flag |
| dstWReady | input | 1 | Destination accepts data beat |

## Verification
The key interaction is a grant pushing an entry into the ordering queue in the same cycle that a last data beat pops the front entry. The timing differs depending on whether the queue is empty, partly filled or full. The bench provokes this with random address and data traffic and random ready stalls, so pushes and pops coincide often. It also runs a directed sequence that fills the queue and then drains it one entry at a time. Every output is compared each cycle against a bench model that holds its own queue and its own rotation pointer.

// File: rtl/wrarb_pkg.sv
package wrarb_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic push;   // address handshake: append granted index
    logic pop;    // last data beat accepted: drop front entry
  } arbStrobe_t;
endpackage

// File: rtl/wrarb_ctrl.sv
module wrarb_ctrl
  import wrarb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] awReqVec,
  input  logic               dstAwReady,
  input  logic               fifoFull,
  input  logic               fifoEmpty,
  input  logic [IDX_W-1:0]   headIdx,
  input  logic [NUM_SRC-1:0] wValidVec,
  input  logic [NUM_SRC-1:0] wLastVec,
  input  logic               dstWReady,
  output arbStrobe_t         strobe,
  output logic [IDX_W-1:0]   grantIdx,
  output logic               dstAwValid,
  output logic [NUM_SRC-1:0] srcAwReady,
  output logic               dstWValid,
  output logic [NUM_SRC-1:0] srcWReady
);
  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(NUM_SRC - 1);

  logic [IDX_W-1:0] rrPtr;
  logic             anyReq;

  // Rotating search starting at rrPtr
  always_comb begin
    logic [IDX_W:0] cand;
    logic           found;
    found    = 1'b0;
    grantIdx = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      cand = {1'b0, rrPtr} + (IDX_W+1)'(k);
      if (cand > LAST_IDX) cand = cand - (IDX_W+1)'(NUM_SRC);
      if (!found && awReqVec[cand[IDX_W-1:0]]) begin
        found    = 1'b1;
        grantIdx = cand[IDX_W-1:0];
      end
    end
    anyReq = found;
  end

  assign dstAwValid = anyReq && !fifoFull;

  always_comb begin
    srcAwReady = '0;
    srcAwReady[grantIdx] = dstAwValid && dstAwReady;
  end

  assign dstWValid = !fifoEmpty && wValidVec[headIdx];

  always_comb begin
    srcWReady = '0;
    srcWReady[headIdx] = !fifoEmpty && dstWReady;
  end

  assign strobe.push = dstAwValid && dstAwReady;
  assign strobe.pop  = dstWValid && dstWReady && wLastVec[headIdx];

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (strobe.push)
      rrPtr <= ({1'b0, grantIdx} == LAST_IDX) ? '0 : grantIdx + 1'b1;
  end

  a_r3_one_aw_ready: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcAwReady));
  a_r4_one_w_ready: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcWReady));
  a_r6_full_stall: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> (!dstAwValid && srcAwReady == '0));
  // R2: with an unchanged set of several requesters, the winner changes
  a_r2_rotates: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && $countones(awReqVec) > 1) ##1
    (dstAwValid && awReqVec == $past(awReqVec)) |-> grantIdx != $past(grantIdx));
  a_r9_no_early_data: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> (!dstWValid && srcWReady == '0));
endmodule

// File: rtl/wrarb_path.sv
module wrarb_path
  import wrarb_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  arbStrobe_t                strobe,
  input  logic [IDX_W-1:0]          grantIdx,
  input  logic [NUM_SRC*ADDR_W-1:0] srcAwAddr,
  input  logic [NUM_SRC*DATA_W-1:0] srcWData,
  input  logic [NUM_SRC-1:0]        srcWLast,
  output logic                      fifoFull,
  output logic                      fifoEmpty,
  output logic [IDX_W-1:0]          headIdx,
  output logic [ADDR_W-1:0]         dstAwAddr,
  output logic [DATA_W-1:0]         dstWData,
  output logic                      dstWLast
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [PTR_W:0]   CNT_FULL = (PTR_W+1)'(FIFO_DEPTH);

  logic [IDX_W-1:0] slots [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;

  assign fifoFull  = (count == CNT_FULL);
  assign fifoEmpty = (count == '0);
  assign headIdx   = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) begin
        slots[wrPtr] <= grantIdx;
        wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      end
      if (strobe.pop)
        rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dstAwAddr = srcAwAddr[grantIdx*ADDR_W +: ADDR_W];
  assign dstWData  = srcWData[headIdx*DATA_W +: DATA_W];
  assign dstWLast  = srcWLast[headIdx];

  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !fifoEmpty);
  a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !fifoFull);
  a_r5_count_track: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/wrOrderArb.sv
module wrOrderArb
  import wrarb_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcAwValid,
  input  logic [NUM_SRC*ADDR_W-1:0] srcAwAddr,
  output logic [NUM_SRC-1:0]        srcAwReady,
  output logic                      dstAwValid,
  output logic [ADDR_W-1:0]         dstAwAddr,
  output logic [IDX_W-1:0]          dstAwSrc,
  input  logic                      dstAwReady,
  input  logic [NUM_SRC-1:0]        srcWValid,
  input  logic [NUM_SRC*DATA_W-1:0] srcWData,
  input  logic [NUM_SRC-1:0]        srcWLast,
  output logic [NUM_SRC-1:0]        srcWReady,
  output logic                      dstWValid,
  output logic [DATA_W-1:0]         dstWData,
  output logic                      dstWLast,
  input  logic                      dstWReady
);
  arbStrobe_t       strobe;
  logic [IDX_W-1:0] grantIdx, headIdx;
  logic             fifoFull, fifoEmpty;

  wrarb_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .awReqVec(srcAwValid), .dstAwReady(dstAwReady),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headIdx(headIdx),
    .wValidVec(srcWValid), .wLastVec(srcWLast), .dstWReady(dstWReady),
    .strobe(strobe), .grantIdx(grantIdx), .dstAwValid(dstAwValid),
    .srcAwReady(srcAwReady), .dstWValid(dstWValid), .srcWReady(srcWReady)
  );

  wrarb_path #(.NUM_SRC(NUM_SRC), .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W),
               .DATA_W(DATA_W), .IDX_W(IDX_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grantIdx(grantIdx),
    .srcAwAddr(srcAwAddr), .srcWData(srcWData), .srcWLast(srcWLast),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headIdx(headIdx),
    .dstAwAddr(dstAwAddr), .dstWData(dstWData), .dstWLast(dstWLast)
  );

  assign dstAwSrc = grantIdx;
endmodule

// File: tb/wrOrderArb_bench.sv
module wrOrderArb_bench;
  localparam int N = 4;
  localparam int D = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] srcAwValid = '0, srcWValid = '0, srcWLast = '0;
  logic [N*AW-1:0] srcAwAddr = '0;
  logic [N*DW-1:0] srcWData = '0;
  logic dstAwReady = 1'b0, dstWReady = 1'b0;
  logic [N-1:0] srcAwReady, srcWReady;
  logic dstAwValid, dstWValid, dstWLast;
  logic [AW-1:0] dstAwAddr;
  logic [DW-1:0] dstWData;
  logic [IW-1:0] dstAwSrc;

  int tests = 0, fails = 0;
  int ptr = 0;
  int q[$];

  always #5 clk = ~clk;

  wrOrderArb #(.NUM_SRC(N), .FIFO_DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u_wrOrderArb (
    .clk(clk), .rstN(rstN), .srcAwValid(srcAwValid), .srcAwAddr(srcAwAddr),
    .srcAwReady(srcAwReady), .dstAwValid(dstAwValid), .dstAwAddr(dstAwAddr),
    .dstAwSrc(dstAwSrc), .dstAwReady(dstAwReady), .srcWValid(srcWValid),
    .srcWData(srcWData), .srcWLast(srcWLast), .srcWReady(srcWReady),
    .dstWValid(dstWValid), .dstWData(dstWData), .dstWLast(dstWLast),
    .dstWReady(dstWReady)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pickGrant();
    for (int k = 0; k < N; k++)
      if (srcAwValid[(ptr + k) % N]) return (ptr + k) % N;
    return -1;
  endfunction

  // Compare every output with the model, then advance the model for the coming edge
  task automatic checkAndStep();
    int g = pickGrant();
    bit full = (q.size() == D);
    bit expAwV = (g >= 0) && !full;
    bit empty = (q.size() == 0);
    int h = empty ? 0 : q[0];
    logic [N-1:0] expAwR = (expAwV && dstAwReady) ? N'(1) << g : '0;
    logic [N-1:0] expWR  = (!empty && dstWReady) ? N'(1) << h : '0;
    bit expWV = !empty && srcWValid[h];
    chk(full ? "R6" : "R7", "dstAwValid", dstAwValid, expAwV);
    chk("R3", "srcAwReady", srcAwReady, expAwR);
    if (expAwV) begin
      chk("R2", "dstAwSrc", dstAwSrc, g);
      chk("R3", "dstAwAddr", dstAwAddr, srcAwAddr[g*AW +: AW]);
    end
    chk(empty ? "R9" : "R8", "dstWValid", dstWValid, expWV);
    chk("R4", "srcWReady", srcWReady, expWR);
    if (!empty) begin
      chk("R8", "dstWData", dstWData, srcWData[h*DW +: DW]);
      chk("R8", "dstWLast", dstWLast, srcWLast[h]);
    end
    if (expWV && dstWReady && srcWLast[h]) void'(q.pop_front()); // R5
    if (expAwV && dstAwReady) begin
      q.push_back(g);
      ptr = (g + 1) % N;
    end
  endtask

  task automatic cycle();
    #1 checkAndStep();
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, no requests
    #1;
    chk("R1", "dstAwValid idle", dstAwValid, 0);
    chk("R1", "dstWValid idle", dstWValid, 0);
    chk("R1", "srcWReady idle", srcWReady, 0);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      srcAwAddr[i*AW +: AW] = 32'h1000 * (i + 1);
      srcWData[i*DW +: DW]  = 32'hD000 + i;
    end
    // Directed: all request, data stalled -> fill queue (R2 rotation, R6 full)
    srcAwValid = '1; dstAwReady = 1'b1; srcWValid = '1; srcWLast = '1; dstWReady = 1'b0;
    repeat (D + 2) cycle();
    chk("R6", "queue full stall", dstAwValid, 0);
    // Drain one entry per cycle while refilling: push and pop together
    dstWReady = 1'b1;
    repeat (8) cycle();
    // Single requester back-to-back (R7) with single-beat writes
    srcAwValid = 4'b0100;
    repeat (6) cycle();
    // Random traffic
    for (int c = 0; c < 3000; c++) begin
      srcAwValid = N'($urandom);
      srcWValid  = N'($urandom);
      srcWLast   = N'($urandom);
      dstAwReady = ($urandom % 4) != 0;
      dstWReady  = ($urandom % 4) != 0;
      for (int i = 0; i < N; i++) begin
        srcAwAddr[i*AW +: AW] = $urandom;
        srcWData[i*DW +: DW]  = $urandom;
      end
      cycle();
    end
    // Drain and confirm empty-queue behaviour (R9)
    srcAwValid = '0; srcWValid = '1; srcWLast = '1; dstWReady = 1'b1;
    repeat (D + 1) cycle();
    #1;
    chk("R9", "drained dstWValid", dstWValid, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule